// File: doc/BRIEF.md
# Configuration Address/Data Window Bridge

This block lets a processor reach the configuration registers of downstream devices indirectly, through two ports on a simple register bus. The processor first writes a 32-bit selector word into the address port. That word names a bus, a device/function and a register, and it carries an enable bit. Accesses to the data port then turn into configuration requests toward the device side. Each request carries the decoded bus, device/function, register offset, a clipped byte length and the write data.

The device side answers with an acknowledge, a presence flag and read data. Reads from a device that is not present, and data-port reads made while the enable bit is clear, return all ones. Writes in either of those cases have no effect. The bridge handles one access at a time. The processor raises `req_valid` for one cycle and then waits for the one-cycle `resp_valid` pulse.

Top module: `cfg_window_bridge`

## Requirements
- R1: After synchronous reset, `resp_valid` and `dev_req` are low and the selector word reads back as 0x00000000, so the data port starts out disabled.
- R2: A write to the address port (`req_port`=0) updates the selector word only if `req_offs`=0 and `req_size` codes four bytes (`req_size` encoding: 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes). Any other offset or size leaves the word unchanged, yet still produces a response.
- R3: A read of the address port returns the whole 32-bit selector word, whatever the size and offset. Every address-port access and every disabled data-port access responds in the cycle after the request, with no device request.
- R4: Bits 30:24 of the selector word are stored and read back, but they do not affect `dev_bus`, `dev_devfn` or `dev_reg`.
- R5: While selector bit 31 is 0, a data-port read returns 0xFFFFFFFF and a data-port write returns 0. Neither raises `dev_req`.
- R6: While bit 31 is 1, a data-port access (`req_port`=1) drives `dev_bus` from bits 23:16 and `dev_devfn` from bits 15:8. `dev_reg` takes bits 7:2 of the word, and its low two bits are word bits 1:0 ORed with `req_offs`. `dev_write` follows the access direction and `dev_wdata` equals `req_wdata`.
- R7: `dev_len` equals the smaller of the requested byte count and 256 minus `dev_reg`, so a request never runs past byte 255.
- R8: Each enabled data-port access raises `dev_req` for exactly one cycle. `resp_valid` rises in the cycle after the cycle in which `dev_ack` is sampled high, and `dev_ack` may already come in the cycle `dev_req` is high.
- R9: A read acknowledged with `dev_present`=1 returns `dev_rdata` with bytes at or above `dev_len` forced to zero. A write acknowledgement returns 0.
- R10: A read acknowledged with `dev_present`=0 returns 0xFFFFFFFF, whatever `dev_rdata` holds.
- R11: A request presented while a device access is outstanding, including the cycle in which `dev_ack` arrives, is ignored: it neither changes the selector word nor produces a response or device request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle processor request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 1 | 0 = address port, 1 = data port |
| req_offs | input | 2 | Byte offset within the selected port |
| req_size | input | 2 | Access size code (00=1, 01=2, 1x=4 bytes) |
| req_wdata | input | 32 | Processor write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Response read data |
| dev_req | output | 1 | One-cycle configuration request to devices |
| dev_write | output | 1 | Request direction, 1 = write |
| dev_bus | output | 8 | Target bus number |
| dev_devfn | output | 8 | Target device/function number |
| dev_reg | output | 8 | Effective register byte offset |
| dev_len | output | 3 | Clipped byte length, 1 to 4 |
| dev_wdata | output | 32 | Write data toward the device |
| dev_ack | input | 1 | Device-side completion strobe |
| dev_present | input | 1 | A device answered at the addressed bus/devfn |
| dev_rdata | input | 32 | Device read data |

## Verification
The collision of interest is a device acknowledge and a new processor request arriving in the same cycle. The acknowledge must complete the pending access, and the new request must be dropped. The bench holds the device latency fixed, issues an enabled read, and drives an address-port write in exactly the cycle in which `dev_ack` is high. It then expects a single response carrying the masked read data, no second response, and an unchanged selector word when the address port is read back.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 8;
    localparam int LEN_W   = 3;
    localparam int BYTES_W = WORD_W / 8;
    localparam int SPACE   = 1 << FIELD_W;

    typedef struct packed {
        logic               busy;
        logic               resp_valid;
        logic [WORD_W-1:0]  resp_rdata;
        logic               dev_req;
        logic               dev_write;
        logic [FIELD_W-1:0] bus;
        logic [FIELD_W-1:0] devfn;
        logic [FIELD_W-1:0] regn;
        logic [LEN_W-1:0]   len;
        logic [WORD_W-1:0]  wdata;
    } seq_state_t;

    // size code: 00 -> 1 byte, 01 -> 2 bytes, 1x -> 4 bytes
    function automatic logic [LEN_W-1:0] size_bytes(input logic [1:0] code);
        logic [LEN_W-1:0] b;
        if (code[1])      b = LEN_W'(BYTES_W);
        else if (code[0]) b = LEN_W'(2);
        else              b = LEN_W'(1);
        return b;
    endfunction

    // bytes that fit before the end of the configuration space
    function automatic logic [LEN_W-1:0] clip_len(input logic [FIELD_W-1:0] regn,
                                                  input logic [LEN_W-1:0]   want);
        logic [FIELD_W:0] room;
        room = (FIELD_W+1)'(SPACE) - {1'b0, regn};
        if ({{(FIELD_W+1-LEN_W){1'b0}}, want} <= room) return want;
        return room[LEN_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < BYTES_W; i++) begin
            m[8*i +: 8] = (LEN_W'(i) < len) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) word_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word = word_q;

endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
(
    input  logic [3*FIELD_W-1:0] sel_low,
    input  logic [1:0]           offs,
    input  logic [1:0]           size,
    output logic [FIELD_W-1:0]   bus,
    output logic [FIELD_W-1:0]   devfn,
    output logic [FIELD_W-1:0]   regn,
    output logic [LEN_W-1:0]     len,
    output logic                 full_word
);

    always_comb begin
        bus       = sel_low[3*FIELD_W-1 -: FIELD_W];
        devfn     = sel_low[2*FIELD_W-1 -: FIELD_W];
        regn      = {sel_low[FIELD_W-1:2], sel_low[1:0] | offs};
        len       = clip_len(regn, size_bytes(size));
        full_word = size[1];
    end

endmodule

// File: rtl/cfgb_sequencer.sv
module cfgb_sequencer
    import cfgb_pkg::*;
#(
    parameter int EN_BIT = WORD_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_port,
    input  logic [1:0]         req_offs,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [WORD_W-1:0]  sel_word,
    input  logic [FIELD_W-1:0] dec_bus,
    input  logic [FIELD_W-1:0] dec_devfn,
    input  logic [FIELD_W-1:0] dec_regn,
    input  logic [LEN_W-1:0]   dec_len,
    input  logic               dec_full,
    input  logic               dev_ack,
    input  logic               dev_present,
    input  logic [WORD_W-1:0]  dev_rdata,
    output logic               sel_wr_en,
    output seq_state_t         state
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.dev_req    = 1'b0;
        st_d.resp_valid = 1'b0;
        sel_wr_en       = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (!req_port) begin
                    st_d.resp_valid = 1'b1;
                    if (req_write) begin
                        sel_wr_en       = dec_full && (req_offs == 2'd0);
                        st_d.resp_rdata = '0;
                    end else begin
                        st_d.resp_rdata = sel_word;
                    end
                end else if (!sel_word[EN_BIT]) begin
                    st_d.resp_valid = 1'b1;
                    st_d.resp_rdata = req_write ? '0 : '1;
                end else begin
                    st_d.busy      = 1'b1;
                    st_d.dev_req   = 1'b1;
                    st_d.dev_write = req_write;
                    st_d.bus       = dec_bus;
                    st_d.devfn     = dec_devfn;
                    st_d.regn      = dec_regn;
                    st_d.len       = dec_len;
                    st_d.wdata     = req_wdata;
                end
            end
        end else if (dev_ack) begin
            st_d.busy       = 1'b0;
            st_d.resp_valid = 1'b1;
            if (st_q.dev_write)  st_d.resp_rdata = '0;
            else if (!dev_present) st_d.resp_rdata = '1;
            else                 st_d.resp_rdata = dev_rdata & len_mask(st_q.len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
    import cfgb_pkg::*;
#(
    parameter int EN_BIT = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_port,
    input  logic [1:0]  req_offs,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        resp_valid,
    output logic [31:0] resp_rdata,
    output logic        dev_req,
    output logic        dev_write,
    output logic [7:0]  dev_bus,
    output logic [7:0]  dev_devfn,
    output logic [7:0]  dev_reg,
    output logic [2:0]  dev_len,
    output logic [31:0] dev_wdata,
    input  logic        dev_ack,
    input  logic        dev_present,
    input  logic [31:0] dev_rdata
);

    localparam int SEL_LOW_W = 3 * FIELD_W;

    logic [WORD_W-1:0]  sel_word;
    logic               sel_wr_en;
    logic [FIELD_W-1:0] dec_bus, dec_devfn, dec_regn;
    logic [LEN_W-1:0]   dec_len;
    logic               dec_full;
    seq_state_t         state;

    cfgb_addr_reg u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel_wr_en),
        .wr_data (req_wdata),
        .word    (sel_word)
    );

    cfgb_decode u_dec (
        .sel_low   (sel_word[SEL_LOW_W-1:0]),
        .offs      (req_offs),
        .size      (req_size),
        .bus       (dec_bus),
        .devfn     (dec_devfn),
        .regn      (dec_regn),
        .len       (dec_len),
        .full_word (dec_full)
    );

    cfgb_sequencer #(.EN_BIT(EN_BIT)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_port    (req_port),
        .req_offs    (req_offs),
        .req_wdata   (req_wdata),
        .sel_word    (sel_word),
        .dec_bus     (dec_bus),
        .dec_devfn   (dec_devfn),
        .dec_regn    (dec_regn),
        .dec_len     (dec_len),
        .dec_full    (dec_full),
        .dev_ack     (dev_ack),
        .dev_present (dev_present),
        .dev_rdata   (dev_rdata),
        .sel_wr_en   (sel_wr_en),
        .state       (state)
    );

    assign resp_valid = state.resp_valid;
    assign resp_rdata = state.resp_rdata;
    assign dev_req    = state.dev_req;
    assign dev_write  = state.dev_write;
    assign dev_bus    = state.bus;
    assign dev_devfn  = state.devfn;
    assign dev_reg    = state.regn;
    assign dev_len    = state.len;
    assign dev_wdata  = state.wdata;

endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker (
    input logic        clk,
    input logic        rst,
    input logic        resp_valid,
    input logic [31:0] resp_rdata,
    input logic        dev_req,
    input logic        dev_write,
    input logic [7:0]  dev_reg,
    input logic [2:0]  dev_len,
    input logic        dev_ack,
    input logic        dev_present
);

    logic rst_q, out_q, wr_q;
    logic pend, wr_eff;

    assign pend   = out_q | dev_req;
    assign wr_eff = dev_req ? dev_write : wr_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            out_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            if (pend && dev_ack) out_q <= 1'b0;
            else if (dev_req)    out_q <= 1'b1;
            if (dev_req) wr_q <= dev_write;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!resp_valid && !dev_req));

    assert_req_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        dev_req |=> !dev_req);

    assert_resp_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (pend && dev_ack) |=> resp_valid);

    assert_no_req_while_pending_R11: assert property (@(posedge clk) disable iff (rst)
        out_q |-> !dev_req);

    assert_len_in_space_R7: assert property (@(posedge clk) disable iff (rst)
        dev_req |-> (dev_len >= 3'd1 && dev_len <= 3'd4 &&
                     ({1'b0, dev_reg} + {6'd0, dev_len}) <= 9'd256));

    assert_absent_read_ones_R10: assert property (@(posedge clk) disable iff (rst)
        (pend && dev_ack && !dev_present && !wr_eff) |=> (resp_rdata == 32'hFFFF_FFFF));

endmodule

bind cfg_window_bridge cfgb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .resp_valid  (resp_valid),
    .resp_rdata  (resp_rdata),
    .dev_req     (dev_req),
    .dev_write   (dev_write),
    .dev_reg     (dev_reg),
    .dev_len     (dev_len),
    .dev_ack     (dev_ack),
    .dev_present (dev_present)
);

// File: tb/cfg_window_bridge_bench.sv
`timescale 1ns/1ps
module cfg_window_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_port = 1'b0;
    logic [1:0]  req_offs = '0, req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, dev_req, dev_write;
    logic [31:0] resp_rdata, dev_wdata;
    logic [7:0]  dev_bus, dev_devfn, dev_reg;
    logic [2:0]  dev_len;
    logic        dev_ack = 1'b0, dev_present = 1'b0;
    logic [31:0] dev_rdata = '0;

    always #2.5 clk = ~clk;

    cfg_window_bridge u_cfg_window_bridge (.*);

    int n_chk = 0, n_fail = 0;
    int req_count = 0, last_lat = 0, force_lat = -1;
    int ack_cnt = 0;
    logic ack_wait = 1'b0;
    logic [7:0]  cap_bus, cap_devfn, cap_reg;
    logic [2:0]  cap_len;
    logic        cap_write;
    logic [31:0] cap_wdata;
    logic [31:0] mdl_word = '0;

    function automatic logic present_at(input logic [7:0] bus, input logic [7:0] devfn);
        return (bus < 8'h10) && (devfn[7:3] != 5'd31);
    endfunction

    function automatic logic [31:0] pattern(input logic [7:0] bus, input logic [7:0] devfn,
                                            input logic [7:0] regn);
        return {~regn, devfn ^ 8'h3C, bus ^ 8'hA5, regn};
    endfunction

    function automatic logic [2:0] exp_len(input logic [7:0] regn, input logic [1:0] sz);
        int want = sz[1] ? 4 : (sz[0] ? 2 : 1);
        int room = 256 - int'(regn);
        return 3'((want < room) ? want : room);
    endfunction

    function automatic logic [31:0] exp_mask(input logic [2:0] len);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (i < int'(len)) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_ack();
        dev_ack     = 1'b1;
        dev_present = present_at(cap_bus, cap_devfn);
        dev_rdata   = dev_present ? pattern(cap_bus, cap_devfn, cap_reg) : $urandom;
    endtask

    // device model
    initial begin
        forever begin
            @(negedge clk);
            dev_ack = 1'b0;
            if (ack_wait) begin
                ack_cnt--;
                if (ack_cnt == 0) begin drive_ack(); ack_wait = 1'b0; end
            end
            if (dev_req) begin
                req_count++;
                cap_bus = dev_bus; cap_devfn = dev_devfn; cap_reg = dev_reg;
                cap_len = dev_len; cap_write = dev_write; cap_wdata = dev_wdata;
                last_lat = (force_lat >= 0) ? force_lat : int'($urandom % 3);
                ack_cnt = last_lat;
                if (ack_cnt == 0) drive_ack();
                else ack_wait = 1'b1;
            end
        end
    end

    task automatic do_access(input logic wr, input logic port, input logic [1:0] offs,
                             input logic [1:0] sz, input logic [31:0] wd,
                             output logic [31:0] rd, output int lat, output int reqs);
        int base = req_count;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_port = port;
        req_offs = offs; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 50) begin @(negedge clk); lat++; end
        rd = resp_rdata;
        reqs = req_count - base;
    endtask

    task automatic addr_op(input logic wr, input logic [1:0] offs, input logic [1:0] sz,
                           input logic [31:0] wd);
        logic [31:0] rd; int lat, reqs;
        do_access(wr, 1'b0, offs, sz, wd, rd, lat, reqs);
        chk("R3 addr-port latency", lat, 1);
        chk("R3 addr-port no device request", reqs, 0);
        if (wr) begin
            if (offs == 2'd0 && sz[1]) mdl_word = wd;
        end else begin
            chk("R3 addr-port readback", rd, mdl_word);
        end
    endtask

    task automatic data_op(input logic wr, input logic [1:0] offs, input logic [1:0] sz,
                           input logic [31:0] wd);
        logic [31:0] rd, exp; int lat, reqs;
        logic [7:0] regn;
        do_access(wr, 1'b1, offs, sz, wd, rd, lat, reqs);
        if (!mdl_word[31]) begin
            chk("R5 disabled no request", reqs, 0);
            chk("R5 disabled latency", lat, 1);
            chk("R5 disabled data", rd, wr ? 32'h0 : 32'hFFFF_FFFF);
        end else begin
            regn = {mdl_word[7:2], mdl_word[1:0] | offs};
            chk("R8 one request pulse", reqs, 1);
            chk("R8 response latency", lat, last_lat + 2);
            chk("R6 bus", cap_bus, mdl_word[23:16]);
            chk("R6 devfn", cap_devfn, mdl_word[15:8]);
            chk("R6 reg", cap_reg, regn);
            chk("R6 direction", cap_write, wr);
            chk("R7 length", cap_len, exp_len(regn, sz));
            if (wr) begin
                chk("R6 wdata", cap_wdata, wd);
                chk("R9 write resp", rd, 32'h0);
            end else begin
                if (present_at(mdl_word[23:16], mdl_word[15:8]))
                    exp = pattern(mdl_word[23:16], mdl_word[15:8], regn) &
                          exp_mask(exp_len(regn, sz));
                else
                    exp = 32'hFFFF_FFFF;
                chk("R9/R10 read data", rd, exp);
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 resp_valid after reset", resp_valid, 0);
        chk("R1 dev_req after reset", dev_req, 0);
        addr_op(1'b0, 2'd0, 2'd2, '0);          // R1: reads 0
        data_op(1'b0, 2'd0, 2'd2, '0);          // R1/R5: disabled
        data_op(1'b1, 2'd0, 2'd2, 32'h1234_5678);

        // R2: ignored writes
        addr_op(1'b1, 2'd0, 2'd2, 32'h8001_0800);
        addr_op(1'b1, 2'd1, 2'd2, 32'hDEAD_BEEF);
        addr_op(1'b1, 2'd0, 2'd1, 32'hDEAD_BEEF);
        addr_op(1'b1, 2'd0, 2'd0, 32'hDEAD_BEEF);
        addr_op(1'b0, 2'd2, 2'd0, '0);          // R3 narrow read sees full word
        chk("R2 word kept", mdl_word, 32'h8001_0800);

        // R4: upper bits stored, no effect on selection
        addr_op(1'b1, 2'd0, 2'd2, 32'hFF02_1004);
        addr_op(1'b0, 2'd0, 2'd2, '0);
        data_op(1'b0, 2'd3, 2'd0, '0);          // R4 fields from 23:0 only

        // R7 boundaries
        addr_op(1'b1, 2'd0, 2'd2, 32'h8000_08FF); data_op(1'b0, 2'd0, 2'd2, '0);
        addr_op(1'b1, 2'd0, 2'd2, 32'h8000_08FE); data_op(1'b0, 2'd1, 2'd2, '0);
        addr_op(1'b1, 2'd0, 2'd2, 32'h8000_08FD); data_op(1'b0, 2'd0, 2'd2, '0);
        addr_op(1'b1, 2'd0, 2'd2, 32'h8000_08FC); data_op(1'b0, 2'd0, 2'd2, '0);
        addr_op(1'b1, 2'd0, 2'd2, 32'h8000_08FE); data_op(1'b1, 2'd0, 2'd1, 32'hCAFE_F00D);

        // R10: absent device (device 31, bus 0x20)
        addr_op(1'b1, 2'd0, 2'd2, 32'h8000_F810); data_op(1'b0, 2'd0, 2'd2, '0);
        addr_op(1'b1, 2'd0, 2'd2, 32'h8020_0010); data_op(1'b0, 2'd0, 2'd1, '0);
        data_op(1'b1, 2'd0, 2'd2, 32'h1111_2222);

        // R11: request collides with the acknowledge
        addr_op(1'b1, 2'd0, 2'd2, 32'h8003_2040);
        force_lat = 2;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_port = 1'b1; req_offs = 2'd0; req_size = 2'd2;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);                         // dev_ack high in this cycle
        req_valid = 1'b1; req_write = 1'b1; req_port = 1'b0; req_offs = 2'd0;
        req_size = 2'd2; req_wdata = 32'h0000_0000;
        @(negedge clk); req_valid = 1'b0;
        chk("R11 ack completes", resp_valid, 1);
        chk("R11 ack data", resp_rdata, pattern(8'h03, 8'h20, 8'h40));
        @(negedge clk);
        chk("R11 no second response", resp_valid, 0);
        chk("R11 no extra request", dev_req, 0);
        force_lat = -1;
        addr_op(1'b0, 2'd0, 2'd2, '0);          // R11: word unchanged

        // random mix
        for (int i = 0; i < 400; i++) begin
            int kind = int'($urandom % 8);
            logic [31:0] w;
            logic [1:0] o = 2'($urandom), s = 2'($urandom);
            if (kind < 2) begin
                w = $urandom;
                w[31] = ($urandom % 4) != 0;
                w[23:16] = ($urandom % 5 == 0) ? 8'h20 : 8'($urandom % 4);
                if ($urandom % 3 == 0) w[7:0] = 8'hFC | 8'($urandom % 4);
                if ($urandom % 2 == 0) begin o = 2'd0; s = 2'd2; end
                addr_op(1'b1, o, s, w);
            end else if (kind == 2) begin
                addr_op(1'b0, o, s, '0);
            end else begin
                data_op(1'($urandom), o, s, $urandom);
            end
        end
        rd = '0;
        finish_run();
    end

endmodule